// File: doc/BRIEF.md
# Timed Marker Scheduler

This block drives a 16-bit marker port whose bits trigger two acquisition channels and four external marker pins. Software-side sequencing issues commands that pair a marker value with an offset. The block adds each offset to a movable time origin to get an absolute due time, queues the command, and writes the value to the port when a free-running tick counter reaches that due time. A shift command moves the origin forward, so every later offset is measured from the new origin.

Two timed return-to-zero forms exist: a brief marker that holds its value for 5 ticks, and an acquisition strobe that holds for 10 ticks. A fixed alignment delay of 25 ticks sits in front of the port. It makes a marker and a signal-generator pulse that are scheduled for the same absolute time leave the chip together. A command that reaches the head of the queue after its due time still goes out, one cycle after it becomes eligible, and sets a sticky late indication.

Top module: `marker_sched`

## Requirements
- R1: While `rst` is high, `marker_out` is 0, `late_flag` is 0, `cmd_ready` is 1 and `tick_now` is 0. After reset `tick_now` increases by one every cycle.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high on a clock edge. For an accepted level command (`cmd_op` = 00) with offset t, the due time is D = origin + t. If the queue holds nothing ahead of it and it was accepted while `tick_now` read q, then `cmd_value` first appears on `marker_out` in the cycle where `tick_now` = max(D, q+1) + 25.
- R3: A level command leaves its value on `marker_out` until the next command from the queue replaces it.
- R4: A brief command (`cmd_op` = 01) shows its value for exactly 5 cycles. `marker_out` then returns to 0, unless another command replaces the value first.
- R5: An acquisition command (`cmd_op` = 10) shows its value for exactly 10 cycles and then returns `marker_out` to 0.
- R6: A shift command (`cmd_op` = 11) adds `cmd_time` to the origin and does not change `marker_out`. Offsets accepted afterwards are measured from the new origin.
- R7: `acq_trig[0]` equals `marker_out[14]` and `acq_trig[1]` equals `marker_out[15]`. `pin_out[i]` equals `marker_out[i]` for i = 0 to 3.
- R8: A command taken from the queue in a cycle where `tick_now` is greater than its due time sets `late_flag` one cycle later. `late_flag` then stays high until reset. Commands taken on time never set it.
- R9: `cmd_ready` is low while 16 commands are waiting. A command offered while `cmd_ready` is low is dropped and never reaches the port.
- R10: Commands leave the queue in acceptance order, at most one per cycle. Several commands due at the same time therefore appear on consecutive cycles.
- R11: A command taken during the hold of a brief or acquisition command replaces the value at once. The earlier hold no longer returns the port to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 00 level, 01 brief, 10 acquisition strobe, 11 origin shift |
| cmd_time | input | 32 | Offset from the origin, or the shift amount |
| cmd_value | input | 16 | Marker value to drive |
| cmd_ready | output | 1 | Queue can take a command |
| tick_now | output | 32 | Free-running absolute tick counter |
| marker_out | output | 16 | Aligned marker port |
| acq_trig | output | 2 | Acquisition triggers (marker bits 15 and 14) |
| pin_out | output | 4 | External marker pins (marker bits 3 to 0) |
| late_flag | output | 1 | Sticky: a command was taken after its due time |

## Verification
The expected port value is due in the cycle where `tick_now` equals the command's release tick plus 25. The release tick is the largest of three ticks: the due time, the accept tick plus one, and the previous release plus one. The return to zero comes 5 or 10 cycles after that port cycle, unless a later release lands at or before it. The late flag is due one cycle after a late release. The bench computes each of these ticks when it offers the command and writes the result into a timeline indexed by tick. On every falling edge it compares the port, the derived triggers and pins, and the late flag against that timeline at the current `tick_now`, so every check is tied to the exact cycle its result is due.

// File: rtl/marker_sched_pkg.sv
`timescale 1ns/1ps
package marker_sched_pkg;

    localparam int unsigned TIME_W   = 32;
    localparam int unsigned MARK_W   = 16;
    localparam int unsigned ACQ0_BIT = 14;
    localparam int unsigned ACQ1_BIT = 15;
    localparam int unsigned PIN_CNT  = 4;

    typedef enum logic [1:0] {
        OP_LEVEL = 2'b00,
        OP_BLIP  = 2'b01,
        OP_ACQ   = 2'b10,
        OP_SHIFT = 2'b11
    } mark_op_e;

    typedef struct packed {
        logic [TIME_W-1:0] due;
        logic [MARK_W-1:0] value;
        mark_op_e          op;
    } mark_entry_t;

    // Number of ticks a released value stays before auto-return (0 = stays)
    function automatic int unsigned hold_ticks(mark_op_e op, int unsigned blip_len,
                                               int unsigned acq_len);
        case (op)
            OP_BLIP: return blip_len;
            OP_ACQ:  return acq_len;
            default: return 0;
        endcase
    endfunction

    function automatic logic [TIME_W-1:0] due_time(logic [TIME_W-1:0] origin,
                                                   logic [TIME_W-1:0] offset);
        return origin + offset;
    endfunction

endpackage

// File: rtl/marker_cmd_fifo.sv
`timescale 1ns/1ps
module marker_cmd_fifo
    import marker_sched_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  mark_entry_t      wr_data,
    input  logic             rd_en,
    output mark_entry_t      rd_data,
    output logic             rd_valid,
    output logic             full,
    output logic [CNT_W-1:0] level
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    mark_entry_t      slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_ok, rd_ok;

    assign full     = (count == CNT_W'(DEPTH));
    assign rd_valid = (count != '0);
    assign wr_ok    = wr_en && !full;
    assign rd_ok    = rd_en && rd_valid;
    assign rd_data  = slots[rd_ptr];
    assign level    = count;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            slots[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

endmodule

// File: rtl/marker_release.sv
`timescale 1ns/1ps
module marker_release
    import marker_sched_pkg::*;
#(
    parameter int unsigned BLIP_TICKS = 5,
    parameter int unsigned ACQ_TICKS  = 10,
    localparam int unsigned HOLD_MAX  = (BLIP_TICKS > ACQ_TICKS) ? BLIP_TICKS : ACQ_TICKS,
    localparam int unsigned HOLD_W    = $clog2(HOLD_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] tick,
    input  mark_entry_t       head,
    input  logic              head_valid,
    output logic              fire,
    output logic              late_flag,
    output logic [MARK_W-1:0] live_value,
    output logic [HOLD_W-1:0] hold_left
);
    logic is_late;

    always_comb begin
        fire    = head_valid && (tick >= head.due);
        is_late = fire && (tick > head.due);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_value <= '0;
            hold_left  <= '0;
            late_flag  <= 1'b0;
        end else begin
            if (fire) begin
                live_value <= head.value;
                hold_left  <= HOLD_W'(hold_ticks(head.op, BLIP_TICKS, ACQ_TICKS));
            end else if (hold_left != '0) begin
                hold_left <= hold_left - HOLD_W'(1);
                if (hold_left == HOLD_W'(1)) begin
                    live_value <= '0;
                end
            end
            if (is_late) begin
                late_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/marker_align_delay.sv
`timescale 1ns/1ps
module marker_align_delay #(
    parameter int unsigned STAGES = 24,
    parameter int unsigned W      = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_direct
            assign dout = din;
        end else begin : g_line
            logic [W-1:0] pipe [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(STAGES); i++) begin
                        pipe[i] <= '0;
                    end
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        pipe[i] <= pipe[i-1];
                    end
                end
            end
            assign dout = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/marker_sched.sv
`timescale 1ns/1ps
module marker_sched
    import marker_sched_pkg::*;
#(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned ALIGN_DELAY  = 25,
    parameter int unsigned BLIP_TICKS   = 5,
    parameter int unsigned ACQ_TICKS    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [TIME_W-1:0] cmd_time,
    input  logic [MARK_W-1:0] cmd_value,
    output logic              cmd_ready,
    output logic [TIME_W-1:0] tick_now,
    output logic [MARK_W-1:0] marker_out,
    output logic [1:0]        acq_trig,
    output logic [PIN_CNT-1:0] pin_out,
    output logic              late_flag
);
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
    localparam int unsigned HOLD_MAX = (BLIP_TICKS > ACQ_TICKS) ? BLIP_TICKS : ACQ_TICKS;
    localparam int unsigned HOLD_W   = $clog2(HOLD_MAX + 1);
    // one stage is the release register itself
    localparam int unsigned LINE_STAGES = (ALIGN_DELAY > 0) ? ALIGN_DELAY - 1 : 0;

    logic [TIME_W-1:0] tick_q;
    logic [TIME_W-1:0] origin_q;
    mark_op_e          op_in;
    logic              accept, enqueue, fifo_full, head_valid, release_fire;
    mark_entry_t       new_entry, head;
    logic [CNT_W-1:0]  fifo_level;
    logic [MARK_W-1:0] live_value;
    logic [HOLD_W-1:0] hold_left;
    logic [TIME_W-1:0] head_due;

    assign op_in    = mark_op_e'(cmd_op);
    assign accept   = cmd_valid && cmd_ready;
    assign enqueue  = accept && (op_in != OP_SHIFT);
    assign head_due = head.due;

    always_comb begin
        new_entry.due   = due_time(origin_q, cmd_time);
        new_entry.value = cmd_value;
        new_entry.op    = op_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q   <= '0;
            origin_q <= '0;
        end else begin
            tick_q <= tick_q + TIME_W'(1);
            if (accept && (op_in == OP_SHIFT)) begin
                origin_q <= origin_q + cmd_time;
            end
        end
    end

    marker_cmd_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (enqueue),
        .wr_data  (new_entry),
        .rd_en    (release_fire),
        .rd_data  (head),
        .rd_valid (head_valid),
        .full     (fifo_full),
        .level    (fifo_level)
    );

    marker_release #(
        .BLIP_TICKS (BLIP_TICKS),
        .ACQ_TICKS  (ACQ_TICKS)
    ) u_release (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_q),
        .head       (head),
        .head_valid (head_valid),
        .fire       (release_fire),
        .late_flag  (late_flag),
        .live_value (live_value),
        .hold_left  (hold_left)
    );

    marker_align_delay #(.STAGES(LINE_STAGES), .W(MARK_W)) u_align (
        .clk  (clk),
        .rst  (rst),
        .din  (live_value),
        .dout (marker_out)
    );

    assign cmd_ready = !fifo_full;
    assign tick_now  = tick_q;
    assign acq_trig  = {marker_out[ACQ1_BIT], marker_out[ACQ0_BIT]};
    assign pin_out   = marker_out[PIN_CNT-1:0];

endmodule

// File: rtl/marker_sched_checker.sv
`timescale 1ns/1ps
module marker_sched_checker #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned TW     = 32,
    parameter int unsigned MW     = 16,
    parameter int unsigned HOLD_W = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic [CNT_W-1:0]  fifo_level,
    input logic              release_fire,
    input logic              head_valid,
    input logic [TW-1:0]     head_due,
    input logic [TW-1:0]     tick_now,
    input logic [MW-1:0]     live_value,
    input logic [HOLD_W-1:0] hold_left,
    input logic              late_flag
);
    assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tick_now == $past(tick_now) + TW'(1));

    assert_fire_not_early_R2: assert property (@(posedge clk) disable iff (rst)
        release_fire |-> tick_now >= head_due);

    assert_hold_ends_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (hold_left == HOLD_W'(1) && !release_fire) |=> live_value == '0);

    assert_late_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        late_flag |=> late_flag);

    assert_late_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(late_flag) |-> ($past(release_fire) && ($past(tick_now) > $past(head_due))));

    assert_ready_full_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> fifo_level == CNT_W'(DEPTH));

    assert_fire_needs_head_R10: assert property (@(posedge clk) disable iff (rst)
        release_fire |-> head_valid);

endmodule

bind marker_sched marker_sched_checker #(
    .DEPTH  (DEPTH),
    .TW     (marker_sched_pkg::TIME_W),
    .MW     (marker_sched_pkg::MARK_W),
    .HOLD_W (HOLD_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_ready    (cmd_ready),
    .fifo_level   (fifo_level),
    .release_fire (release_fire),
    .head_valid   (head_valid),
    .head_due     (head_due),
    .tick_now     (tick_now),
    .live_value   (live_value),
    .hold_left    (hold_left),
    .late_flag    (late_flag)
);

// File: tb/marker_sched_bench.sv
`timescale 1ns/1ps
module marker_sched_bench;
    localparam int DLY = 25;
    localparam int BLIP = 5;
    localparam int ACQ = 10;
    localparam int TL = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_time = '0;
    logic [15:0] cmd_value = '0;
    logic        cmd_ready;
    logic [31:0] tick_now;
    logic [15:0] marker_out;
    logic [1:0]  acq_trig;
    logic [3:0]  pin_out;
    logic        late_flag;

    always #4 clk = ~clk;

    marker_sched u_marker_sched (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_time(cmd_time), .cmd_value(cmd_value), .cmd_ready(cmd_ready),
        .tick_now(tick_now), .marker_out(marker_out), .acq_trig(acq_trig),
        .pin_out(pin_out), .late_flag(late_flag)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit [15:0] ev_val [TL];
    bit        ev_ok  [TL];
    string     ev_tag [TL];

    longint ref_m = 0;
    longint last_rel = -1;
    longint zero_at = -1;
    longint late_tick = -1;
    longint last_ev = 0;
    logic [15:0] cur_exp = '0;
    string cur_tag = "R1";
    bit cmp_on = 1'b0;

    function automatic longint lmax(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

    function automatic int hold_of(int op);
        if (op == 1) return BLIP;
        if (op == 2) return ACQ;
        return 0;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at tick %0d: actual %0h expected %0h", tag, what, tick_now, act, exp);
        end
    endtask

    task automatic set_ev(longint at, logic [15:0] v, string tag);
        if (at < TL) begin
            ev_ok[at] = 1'b1;
            ev_val[at] = v;
            ev_tag[at] = tag;
        end
        last_ev = lmax(last_ev, at);
    endtask

    // expected schedule derived from the timing rules of R2..R11
    task automatic model(int op, longint t, logic [15:0] v, longint q, string tag);
        longint abs_t, rel, x;
        int h;
        if (op == 3) begin
            ref_m += t;
            return;
        end
        abs_t = ref_m + t;
        rel = lmax(lmax(abs_t, q + 1), last_rel + 1);
        last_rel = rel;
        if (rel > abs_t && late_tick < 0) late_tick = rel + 1;
        x = rel + DLY;
        if (zero_at >= x) begin
            if (zero_at < TL) ev_ok[zero_at] = 1'b0;
            zero_at = -1;
        end
        set_ev(x, v, tag);
        h = hold_of(op);
        if (h > 0) begin
            zero_at = x + h;
            set_ev(zero_at, 16'h0000, tag);
        end
    endtask

    task automatic push(int op, longint t, logic [15:0] v, string tag);
        longint q;
        bit rdy;
        @(negedge clk);
        q = tick_now;
        rdy = cmd_ready;
        cmd_valid = 1'b1;
        cmd_op = 2'(op);
        cmd_time = 32'(t);
        cmd_value = v;
        if (rdy) model(op, t, v, q, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (longint'(tick_now) <= last_ev + 3) @(negedge clk);
    endtask

    task automatic sync_here();
        longint s;
        s = longint'(tick_now) + 1 - ref_m;
        if (s < 0) s = 0;
        push(3, s, 16'h0, "R6");
    endtask

    // continuous comparison against the timeline at the current tick
    always @(negedge clk) begin
        if (cmp_on) begin
            int k;
            k = int'(tick_now);
            if (k < TL && ev_ok[k]) begin
                cur_exp = ev_val[k];
                cur_tag = ev_tag[k];
            end
            check(marker_out == cur_exp, cur_tag, "marker_out", marker_out, cur_exp);
            check(acq_trig == {cur_exp[15], cur_exp[14]} && pin_out == cur_exp[3:0],
                  "R7", "acq/pins", {acq_trig, pin_out}, {cur_exp[15], cur_exp[14], cur_exp[3:0]});
            check(late_flag == (late_tick >= 0 && k >= late_tick), "R8", "late_flag",
                  late_flag, (late_tick >= 0 && k >= late_tick));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7151));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(marker_out == 16'h0, "R1", "marker_out in reset", marker_out, 0);
        check(late_flag == 1'b0, "R1", "late_flag in reset", late_flag, 0);
        check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
        check(tick_now == 32'd0, "R1", "tick_now in reset", tick_now, 0);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R2/R3/R7: level commands hold their value
        push(0, 20, 16'hC00A, "R2");
        push(0, 60, 16'h4003, "R3");
        drain();

        // R4 brief, then R5 acquisition strobe
        sync_here();
        push(1, 20, 16'h000F, "R4");
        push(2, 50, 16'h8000, "R5");
        push(2, 80, 16'h4005, "R5");
        drain();

        // R11: a level command cuts a brief hold short
        sync_here();
        push(1, 20, 16'h00F0, "R11");
        push(0, 22, 16'h0011, "R11");
        drain();

        // R6: shift the origin, later offsets measured from it
        sync_here();
        push(3, 100, 16'hFFFF, "R6");
        push(0, 5, 16'h0606, "R6");
        drain();

        // R2 random mix with occasional shifts
        sync_here();
        begin
            longint la;
            la = ref_m + 60;
            for (int i = 0; i < 60; i++) begin
                int r;
                r = int'($urandom % 10);
                if (r == 0 && ref_m + 4 < la) begin
                    push(3, longint'($urandom % 4), 16'h0, "R6");
                end else begin
                    int op;
                    la += 1 + longint'($urandom % 9);
                    op = (r < 6) ? 0 : ((r < 8) ? 1 : 2);
                    push(op, la - ref_m, 16'($urandom), "R2");
                end
            end
        end
        drain();
        check(late_flag == 1'b0, "R8", "late_flag after on-time traffic", late_flag, 0);

        // R8: a command already in the past
        sync_here();
        idle();
        repeat (30) @(negedge clk);
        push(0, 3, 16'h0100, "R8");
        drain();
        check(late_flag == 1'b1, "R8", "late_flag after late command", late_flag, 1);

        // R10: same due time, released in order on consecutive ticks
        sync_here();
        push(0, 40, 16'h0001, "R10");
        push(0, 40, 16'h0002, "R10");
        push(0, 40, 16'h0003, "R10");
        drain();

        // R9: fill the queue, drop the extra command
        sync_here();
        for (int i = 0; i < 16; i++) begin
            push(0, 200 + 2 * i, 16'(16'h2000 + i), "R9");
        end
        push(0, 240, 16'hDEAD, "R9");
        idle();
        check(cmd_ready == 1'b0, "R9", "cmd_ready with full queue", cmd_ready, 0);
        drain();
        check(cmd_ready == 1'b1, "R9", "cmd_ready after drain", cmd_ready, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule